// File: doc/BRIEF.md
# Host Port Register Window with Two-Way Mailbox

This block is a slave port through which an outside processor reaches an on-chip word memory over a 16-bit bus. The bus is asynchronous and uses active-low strobes. Two select lines pick one of four registers: a data window, a mailbox, a memory pointer and a status word. The data window reads or writes the memory word that the pointer addresses. The pointer then moves on by itself, so a block of words can be transferred after loading the pointer only once.

The mailbox carries one message in each direction. A host write fills the inbound slot and raises an interrupt toward the internal side. An internal write fills the outbound slot and raises the host interrupt. Reading a slot empties it. A configuration input can reverse the byte order of data-window transfers.

The strobes are brought into the internal clock domain through a synchronizer chain. A read loads the output register when the strobe goes active. Every side effect of a transfer takes place when its strobe returns high.

Top module: `hostPortMbox`

## Requirements
- R1: After reset, both interrupt outputs are low, the status register reads 0 and the pointer register reads 0.
- R2: Select code 2'b10 is the pointer. A write loads it with the written value, with bit 0 forced to 0 and truncated to the byte-address width. A read returns it zero-extended.
- R3: Select code 2'b00 is the data window. A write stores into memory word pointer/2, a read returns that word, and each completed access adds 2 to the pointer.
- R4: The pointer wraps from the highest even byte address to 0, so the write that follows lands in word 0.
- R5: A host write to select code 2'b01 places the value on the internal inbound-mailbox output, sets status bit 1 and raises the internal interrupt.
- R6: An internal read pulse clears the internal interrupt and status bit 1.
- R7: An internal write pulse loads the outbound mailbox, sets status bit 0 and raises the host interrupt. A host read of select code 2'b01 returns that value and then clears both.
- R8: With the byte-swap input high, data-window writes store {data[7:0],data[15:8]} and reads return the stored word with its bytes exchanged. Pointer and mailbox transfers are never swapped.
- R9: A host write to the status register (select code 2'b11) changes neither the pointer nor the mailbox flags. Status bits 15..2 always read 0.
- R10: Read or write strobes while chip select is high have no effect.
- R11: A host read of the mailbox or data window has no side effect while the strobe is still low. Its effect appears only after the strobe returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostCsN | input | 1 | Host chip select, active low |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostSel | input | 2 | Register select |
| hostDataIn | input | 16 | Host write data |
| hostDataOut | output | 16 | Host read data, loaded when a read strobe becomes active |
| hostIrq | output | 1 | Outbound message waiting for the host |
| byteSwapEn | input | 1 | Swap bytes on data-window transfers |
| coreMboxWrEn | input | 1 | Internal pulse that loads the outbound mailbox |
| coreMboxWrData | input | 16 | Outbound message value |
| coreMboxRdEn | input | 1 | Internal pulse that consumes the inbound message |
| coreMboxRdData | output | 16 | Inbound message value |
| coreIrq | output | 1 | Inbound message waiting for the internal side |

## Verification
The main memory path is exercised with random blocks of random start address, length and byte order, written and then read back under an independently chosen swap setting. A wrong pointer step, a wrong word index or an asymmetric swap each produce a different mismatch pattern. Directed cases cover the wrap at the top of memory, strobes with chip select high, writes to the status register, and mailbox traffic in both directions. The mailbox cases sample the host interrupt while the read strobe is still low and again after release, which shows whether the clear happens at the right edge.

// File: rtl/hpm_pkg.sv
package hpmPkg;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    SEL_DATA = 2'b00,
    SEL_MBOX = 2'b01,
    SEL_PTR  = 2'b10,
    SEL_STAT = 2'b11
  } hostSel_e;

  // strobes handed from control to datapath, one cycle wide
  typedef struct packed {
    logic              rdStart;
    logic              rdEnd;
    logic              wrEnd;
    hostSel_e          sel;
    logic [DATA_W-1:0] data;
  } hostCtl_t;

  function automatic logic [DATA_W-1:0] swapBytes(input logic [DATA_W-1:0] v, input logic en);
    return en ? {v[7:0], v[15:8]} : v;
  endfunction
endpackage

// File: rtl/hpm_ctrl.sv
module hpmCtrl
  import hpmPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCsN,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic [1:0]        hostSel,
  input  logic [DATA_W-1:0] hostDataIn,
  output hostCtl_t          ctl
);
  localparam int BUS_W = DATA_W + 2;

  logic [SYNC_STAGES-1:0] rdSync, wrSync;
  logic [BUS_W-1:0]       busSync [SYNC_STAGES];
  logic                   rdAct, wrAct, rdPrev, wrPrev;
  logic [BUS_W-1:0]       busNow, busHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdSync <= '0;
      wrSync <= '0;
    end else begin
      rdSync <= {rdSync[SYNC_STAGES-2:0], ~hostCsN & ~hostRdN};
      wrSync <= {wrSync[SYNC_STAGES-2:0], ~hostCsN & ~hostWrN};
    end
  end

  // select and data travel through the same number of stages as the strobes
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_busSync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) busSync[s] <= '0;
        else       busSync[s] <= {hostSel, hostDataIn};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) busSync[s] <= '0;
        else       busSync[s] <= busSync[s-1];
      end
    end
  end

  assign rdAct  = rdSync[SYNC_STAGES-1];
  assign wrAct  = wrSync[SYNC_STAGES-1];
  assign busNow = busSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPrev  <= 1'b0;
      wrPrev  <= 1'b0;
      busHold <= '0;
      ctl     <= '0;
    end else begin
      rdPrev <= rdAct;
      wrPrev <= wrAct;
      if (rdAct || wrAct) busHold <= busNow;
      ctl.rdStart <= rdAct & ~rdPrev;
      ctl.rdEnd   <= ~rdAct & rdPrev;
      ctl.wrEnd   <= ~wrAct & wrPrev;
      if (rdAct || wrAct) begin
        ctl.sel  <= hostSel_e'(busNow[BUS_W-1 -: 2]);
        ctl.data <= busNow[DATA_W-1:0];
      end else begin
        ctl.sel  <= hostSel_e'(busHold[BUS_W-1 -: 2]);
        ctl.data <= busHold[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/hpm_datapath.sv
module hpmDatapath
  import hpmPkg::*;
#(
  parameter int MEM_WORDS = 256,
  parameter int PTR_W     = $clog2(MEM_WORDS) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostCtl_t          ctl,
  input  logic              byteSwapEn,
  input  logic              coreMboxWrEn,
  input  logic [DATA_W-1:0] coreMboxWrData,
  input  logic              coreMboxRdEn,
  output logic [DATA_W-1:0] coreMboxRdData,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostIrq,
  output logic              coreIrq,
  output logic [PTR_W-1:0]  ptrByte
);
  logic [DATA_W-1:0] mem [MEM_WORDS];
  logic [DATA_W-1:0] inMbox, outMbox;
  logic              inFull, outFull;
  logic [PTR_W-2:0]  wordIdx;
  logic [DATA_W-1:0] statusWord, readMux;
  logic              dataWr, dataRd, mboxWr, mboxRd, ptrWr;

  assign wordIdx    = ptrByte[PTR_W-1:1];
  assign statusWord = {{(DATA_W-2){1'b0}}, inFull, outFull};
  assign dataWr = ctl.wrEnd && ctl.sel == SEL_DATA;
  assign dataRd = ctl.rdEnd && ctl.sel == SEL_DATA;
  assign mboxWr = ctl.wrEnd && ctl.sel == SEL_MBOX;
  assign mboxRd = ctl.rdEnd && ctl.sel == SEL_MBOX;
  assign ptrWr  = ctl.wrEnd && ctl.sel == SEL_PTR;

  always_comb begin
    unique case (ctl.sel)
      SEL_DATA: readMux = swapBytes(mem[wordIdx], byteSwapEn);
      SEL_MBOX: readMux = outMbox;
      SEL_PTR:  readMux = DATA_W'(ptrByte);
      default:  readMux = statusWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (dataWr) mem[wordIdx] <= swapBytes(ctl.data, byteSwapEn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrByte     <= '0;
      inMbox      <= '0;
      outMbox     <= '0;
      inFull      <= 1'b0;
      outFull     <= 1'b0;
      hostDataOut <= '0;
    end else begin
      if (ctl.rdStart) hostDataOut <= readMux;
      if (ptrWr)                 ptrByte <= {ctl.data[PTR_W-1:1], 1'b0};
      else if (dataWr || dataRd) ptrByte <= ptrByte + PTR_W'(2);
      if (mboxWr) inMbox <= ctl.data;
      if (mboxWr)            inFull <= 1'b1;
      else if (coreMboxRdEn) inFull <= 1'b0;
      if (coreMboxWrEn) outMbox <= coreMboxWrData;
      if (coreMboxWrEn) outFull <= 1'b1;
      else if (mboxRd)  outFull <= 1'b0;
    end
  end

  assign coreMboxRdData = inMbox;
  assign hostIrq        = outFull;
  assign coreIrq        = inFull;
endmodule

// File: rtl/host_port_mbox.sv
module hostPortMbox
  import hpmPkg::*;
#(
  parameter int MEM_WORDS   = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostCsN,
  input  logic        hostRdN,
  input  logic        hostWrN,
  input  logic [1:0]  hostSel,
  input  logic [15:0] hostDataIn,
  output logic [15:0] hostDataOut,
  output logic        hostIrq,
  input  logic        byteSwapEn,
  input  logic        coreMboxWrEn,
  input  logic [15:0] coreMboxWrData,
  input  logic        coreMboxRdEn,
  output logic [15:0] coreMboxRdData,
  output logic        coreIrq
);
  localparam int PTR_W = $clog2(MEM_WORDS) + 1;

  hostCtl_t         ctlBus;
  logic [PTR_W-1:0] ptrByte;

  hpmCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostRdN(hostRdN),
    .hostWrN(hostWrN), .hostSel(hostSel), .hostDataIn(hostDataIn), .ctl(ctlBus)
  );

  hpmDatapath #(.MEM_WORDS(MEM_WORDS), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctlBus), .byteSwapEn(byteSwapEn),
    .coreMboxWrEn(coreMboxWrEn), .coreMboxWrData(coreMboxWrData),
    .coreMboxRdEn(coreMboxRdEn), .coreMboxRdData(coreMboxRdData),
    .hostDataOut(hostDataOut), .hostIrq(hostIrq), .coreIrq(coreIrq),
    .ptrByte(ptrByte)
  );
endmodule

// File: rtl/host_port_mbox_chk.sv
module hostPortMboxChk
  import hpmPkg::*;
#(
  parameter int PTR_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input hostCtl_t         ctl,
  input logic [PTR_W-1:0] ptr,
  input logic [15:0]      hostDataOut,
  input logic             hostIrq,
  input logic             coreIrq,
  input logic             coreMboxWrEn,
  input logic             coreMboxRdEn
);
  assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrEnd && ctl.sel == SEL_PTR) |=> ptr == {$past(ctl.data[PTR_W-1:1]), 1'b0});

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((ctl.wrEnd || ctl.rdEnd) && ctl.sel == SEL_DATA) |=> ptr == $past(ptr) + PTR_W'(2));

  assert_in_raise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreIrq) |-> $past(ctl.wrEnd && ctl.sel == SEL_MBOX));

  assert_in_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreIrq) |-> $past(coreMboxRdEn));

  assert_out_raise_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostIrq) |-> $past(coreMboxWrEn));

  assert_stat_ignore_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrEnd && ctl.sel == SEL_STAT) |=> $stable(ptr));

  assert_out_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hostIrq) |-> $past(ctl.rdEnd && ctl.sel == SEL_MBOX));

  assert_rd_load_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(hostDataOut) |-> $past(ctl.rdStart));
endmodule

bind hostPortMbox hostPortMboxChk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctl(ctlBus), .ptr(ptrByte), .hostDataOut(hostDataOut),
  .hostIrq(hostIrq), .coreIrq(coreIrq), .coreMboxWrEn(coreMboxWrEn),
  .coreMboxRdEn(coreMboxRdEn)
);

// File: tb/test_hostPortMbox.sv
module test_hostPortMbox;
  localparam int MEM_WORDS = 256;
  localparam int PTR_MOD   = MEM_WORDS * 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic hostCsN = 1'b1, hostRdN = 1'b1, hostWrN = 1'b1;
  logic [1:0] hostSel = 2'b00;
  logic [15:0] hostDataIn = '0, hostDataOut;
  logic hostIrq, coreIrq, byteSwapEn = 1'b0;
  logic coreMboxWrEn = 1'b0, coreMboxRdEn = 1'b0;
  logic [15:0] coreMboxWrData = '0, coreMboxRdData;

  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;
  logic [15:0] model [MEM_WORDS];

  always #2 clk = ~clk;

  hostPortMbox #(.MEM_WORDS(MEM_WORDS)) i_hostPortMbox (
    .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostRdN(hostRdN), .hostWrN(hostWrN),
    .hostSel(hostSel), .hostDataIn(hostDataIn), .hostDataOut(hostDataOut),
    .hostIrq(hostIrq), .byteSwapEn(byteSwapEn), .coreMboxWrEn(coreMboxWrEn),
    .coreMboxWrData(coreMboxWrData), .coreMboxRdEn(coreMboxRdEn),
    .coreMboxRdData(coreMboxRdData), .coreIrq(coreIrq)
  );

  function automatic logic [15:0] swp(input logic [15:0] v, input logic en);
    return en ? {v[7:0], v[15:8]} : v;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] sel, input logic [15:0] d, input logic cs = 1'b1);
    @(negedge clk);
    hostSel = sel; hostDataIn = d; hostCsN = ~cs; hostWrN = 1'b0;
    repeat (5) @(negedge clk);
    hostWrN = 1'b1; hostCsN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic hostReadHold(input logic [1:0] sel, output logic [15:0] d);
    @(negedge clk);
    hostSel = sel; hostCsN = 1'b0; hostRdN = 1'b0;
    repeat (6) @(negedge clk);
    d = hostDataOut;
  endtask

  task automatic hostRelease();
    hostRdN = 1'b1; hostCsN = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic hostRead(input logic [1:0] sel, output logic [15:0] d);
    hostReadHold(sel, d);
    hostRelease();
  endtask

  task automatic corePulse(input logic wr, input logic [15:0] d);
    @(negedge clk);
    if (wr) begin coreMboxWrEn = 1'b1; coreMboxWrData = d; end
    else coreMboxRdEn = 1'b1;
    @(negedge clk);
    coreMboxWrEn = 1'b0; coreMboxRdEn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1 hostIrq", 16'(hostIrq), 16'h0);
    check("R1 coreIrq", 16'(coreIrq), 16'h0);
    hostRead(2'b11, r); check("R1 status", r, 16'h0);
    hostRead(2'b10, r); check("R1 pointer", r, 16'h0);

    // R2 pointer load, bit 0 forced low, truncated to 9 bits
    hostWrite(2'b10, 16'hFE25); hostRead(2'b10, r); check("R2 ptr", r, 16'h0024);

    // R4 wrap at top of memory
    hostWrite(2'b10, 16'(PTR_MOD - 2));
    hostWrite(2'b00, 16'hA1A2); hostWrite(2'b00, 16'hB1B2);
    model[MEM_WORDS-1] = 16'hA1A2; model[0] = 16'hB1B2;
    hostRead(2'b10, r); check("R4 ptr after wrap", r, 16'h0002);
    hostWrite(2'b10, 16'h0000); hostRead(2'b00, r); check("R4 word0", r, 16'hB1B2);

    // R10 strobes without chip select
    hostWrite(2'b10, 16'h0040);
    hostWrite(2'b10, 16'h0100, 1'b0);
    hostWrite(2'b00, 16'hDEAD, 1'b0);
    hostRead(2'b10, r); check("R10 ptr untouched", r, 16'h0040);

    // R9 status write ignored
    hostWrite(2'b11, 16'hFFFF);
    hostRead(2'b10, r); check("R9 ptr", r, 16'h0040);
    hostRead(2'b11, r); check("R9 status", r, 16'h0000);

    // R3 / R8 random blocks
    for (int b = 0; b < 24; b++) begin
      int start, len;
      logic swW, swR;
      start = int'($urandom_range(MEM_WORDS - 1));
      len   = int'($urandom_range(8, 1));
      swW   = 1'($urandom_range(1)); swR = 1'($urandom_range(1));
      byteSwapEn = swW;
      hostWrite(2'b10, 16'(start * 2));
      for (int k = 0; k < len; k++) begin
        logic [15:0] d;
        d = 16'($urandom);
        hostWrite(2'b00, d);
        model[(start + k) % MEM_WORDS] = swp(d, swW);
      end
      hostRead(2'b10, r); check("R3 ptr after block write", r, 16'(((start + len) % MEM_WORDS) * 2));
      byteSwapEn = swR;
      hostWrite(2'b10, 16'(start * 2));
      for (int k = 0; k < len; k++) begin
        hostRead(2'b00, r);
        check(swR ? "R8 swapped read" : "R3 data read", r, swp(model[(start + k) % MEM_WORDS], swR));
      end
      hostRead(2'b10, r); check("R3 ptr after block read", r, 16'(((start + len) % MEM_WORDS) * 2));
    end

    // R8 pointer not swapped
    byteSwapEn = 1'b1;
    hostWrite(2'b10, 16'h0102); hostRead(2'b10, r); check("R8 ptr unswapped", r, 16'h0102);

    // R5 / R6 inbound mailbox, R8 mailbox unswapped
    for (int m = 0; m < 4; m++) begin
      logic [15:0] v;
      v = 16'($urandom);
      hostWrite(2'b01, v);
      check("R5 inbound value", coreMboxRdData, v);
      check("R5 coreIrq", 16'(coreIrq), 16'h1);
      hostRead(2'b11, r); check("R5 status", r, 16'h0002);
      corePulse(1'b0, 16'h0);
      check("R6 coreIrq cleared", 16'(coreIrq), 16'h0);
      hostRead(2'b11, r); check("R6 status", r, 16'h0000);
    end

    // R7 / R11 outbound mailbox
    for (int m = 0; m < 4; m++) begin
      logic [15:0] v;
      v = 16'($urandom);
      corePulse(1'b1, v);
      check("R7 hostIrq", 16'(hostIrq), 16'h1);
      hostRead(2'b11, r); check("R7 status", r, 16'h0001);
      hostReadHold(2'b01, r);
      check("R7 outbound value", r, v);
      check("R11 hostIrq while strobe low", 16'(hostIrq), 16'h1);
      hostRelease();
      check("R11 hostIrq after release", 16'(hostIrq), 16'h0);
      hostRead(2'b11, r); check("R7 status cleared", r, 16'h0000);
    end

    // R11 data read: pointer steps only after release
    byteSwapEn = 1'b0;
    hostWrite(2'b10, 16'h0000);
    hostReadHold(2'b00, r); check("R11 data during strobe", r, model[0]);
    hostRelease();
    hostRead(2'b10, r); check("R11 ptr after data read", r, 16'h0002);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule